// File: doc/BRIEF.md
# Transparent Window Address Matcher

This block checks one access stream against two programmable address windows. When an access falls inside an enabled window whose privilege filter accepts the current mode, the access is declared transparent. The logical address is then passed straight through as the physical address, and the translation cache is neither consulted nor changed. A window covers a region between 16 MB and the full 4 GB. Its base byte is compared with the top byte of the address, and each set mask bit excludes the matching address bit from that compare.

An instruction stream and a data stream each use one instance, so each stream has its own pair of windows. The match, fault and address outputs are combinational from the access inputs, so the block can work in parallel with a translation cache lookup. A synchronous write port loads one window's settings per clock.

The configuration word, with bit positions that software must respect, is: bits 7:0 base, bits 15:8 mask, bit 16 enable, bits 18:17 privilege filter, bit 19 write protect.

Top module: `tt_window_match`

## Requirements
- R1: After reset every window is disabled, so no address matches, `hit` and `wr_fault` are 0 and `phys_addr` is 0.
- R2: An enabled window matches when `((acc_addr[31:24] ^ base) & ~mask) == 0`, where base is config bits 7:0 and mask is config bits 15:8.
- R3: A window whose mask is 8'hFF matches every address, provided its privilege filter accepts the mode.
- R4: A window whose enable bit (config bit 16) is 0 never matches, whatever its base and mask.
- R5: The privilege filter (config bits 18:17) accepts user accesses only (`acc_super`=0) when it is 2'b00, supervisor accesses only when it is 2'b01, and both modes when it is 2'b10 or 2'b11.
- R6: When `hit` is 1, `phys_addr` equals `acc_addr` in all 32 bits. When `hit` is 0, `phys_addr` is 0.
- R7: `wr_fault` is 1 exactly when `acc_write` is 1 and at least one matching window has its write-protect bit (config bit 19) set. Reads never fault.
- R8: `hit` is 1 when either window matches, and overlapping windows are allowed.
- R9: A write with `cfg_we`=1 loads `cfg_wdata` into window `cfg_idx` at the rising clock edge and leaves the other window unchanged. Without `cfg_we`, the settings hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 1 | Window selected for the write |
| cfg_wdata | input | 20 | Window settings word |
| acc_addr | input | 32 | Logical address of the access |
| acc_super | input | 1 | 1 for a supervisor access, 0 for a user access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| hit | output | 1 | Access is transparent |
| phys_addr | output | 32 | Physical address when `hit` is 1, otherwise 0 |
| wr_fault | output | 1 | Write to a protected window |

## Verification
The assertions assume that the access inputs are settled before each rising edge and that the configuration only changes through `cfg_we`. They also assume that reset is applied once at the start. The stimulus changes the access inputs and the write strobe only on falling edges, and it writes settings only while reset is released. It then sweeps all 256 top-byte values in every mode and direction combination for each window setup, so every sampled input is stable and legal.

// File: rtl/tt_window_match.sv
module tt_window_match #(
  parameter int AW   = 32,
  parameter int SW   = 8,
  parameter int NWIN = 2,
  localparam int IDXW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int CW   = 2 * SW + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [CW-1:0]   cfg_wdata,
  input  logic [AW-1:0]   acc_addr,
  input  logic            acc_super,
  input  logic            acc_write,
  output logic            hit,
  output logic [AW-1:0]   phys_addr,
  output logic            wr_fault
);

  localparam int EN_B = 2 * SW;
  localparam int PR_B = 2 * SW + 1;
  localparam int WP_B = 2 * SW + 3;

  logic [NWIN*CW-1:0] cfg_flat;
  logic [NWIN-1:0]    win_hit;
  logic [NWIN-1:0]    win_wp;
  wire  [SW-1:0]      top = acc_addr[AW-1 -: SW];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [CW-1:0] cfg_q;
    wire  [SW-1:0] base = cfg_q[SW-1:0];
    wire  [SW-1:0] mask = cfg_q[2*SW-1:SW];
    wire  [1:0]    priv = cfg_q[PR_B+1:PR_B];
    wire           mode_ok = priv[1] | (priv[0] == acc_super);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cfg_q <= '0;
      else if (cfg_we && cfg_idx == IDXW'(i)) cfg_q <= cfg_wdata;

    assign win_hit[i] = cfg_q[EN_B] & mode_ok & ~|((top ^ base) & ~mask);
    assign win_wp[i]  = cfg_q[WP_B];
    assign cfg_flat[i*CW +: CW] = cfg_q;
  end

  assign hit       = |win_hit;
  assign wr_fault  = acc_write & |(win_hit & win_wp);
  assign phys_addr = hit ? acc_addr : '0;

endmodule

// File: rtl/tt_window_match_sva.sv
module tt_window_match_sva #(
  parameter int AW = 32,
  parameter int FW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [AW-1:0] acc_addr,
  input logic          acc_write,
  input logic          hit,
  input logic [AW-1:0] phys_addr,
  input logic          wr_fault,
  input logic [FW-1:0] cfg_flat
);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_flat == '0 && !hit));

  a_r6_phys_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> phys_addr == acc_addr);

  a_r6_phys_zero_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> phys_addr == '0);

  a_r7_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_write |-> !wr_fault);

  a_r7_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> hit);

  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_flat));

endmodule

bind tt_window_match tt_window_match_sva #(.AW(AW), .FW(NWIN*CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .acc_addr(acc_addr),
  .acc_write(acc_write), .hit(hit), .phys_addr(phys_addr),
  .wr_fault(wr_fault), .cfg_flat(cfg_flat)
);

// File: tb/tt_window_match_test.sv
`timescale 1ns/1ps
module tt_window_match_test;
  logic        clk = 0, rst_n = 0, cfg_we = 0, cfg_idx = 0;
  logic [19:0] cfg_wdata = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_super = 0, acc_write = 0;
  logic        hit, wr_fault;
  logic [31:0] phys_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_base [2], m_mask [2];
  logic [1:0] m_priv [2];
  logic       m_en [2], m_wp [2];

  always #2.5 clk = ~clk;

  tt_window_match uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_super(acc_super),
    .acc_write(acc_write), .hit(hit), .phys_addr(phys_addr), .wr_fault(wr_fault)
  );

  function automatic bit win_match(int w, logic [7:0] t, logic s);
    bit mode_ok = m_priv[w][1] || (m_priv[w][0] == s);
    return m_en[w] && mode_ok && (((t ^ m_base[w]) & ~m_mask[w]) == 8'h00);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h super=%0b write=%0b actual=%h expected=%h",
               tag, acc_addr, acc_super, acc_write, act, exp);
    end
  endtask

  // R9: load one window through the write port and mirror it in the model
  task automatic put_win(int idx, bit en, logic [7:0] base, logic [7:0] mask,
                         logic [1:0] priv, bit wp);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx[0];
    cfg_wdata = {wp, priv, en, mask, base};
    @(negedge clk);
    cfg_we = 0;
    m_en[idx] = en; m_base[idx] = base; m_mask[idx] = mask;
    m_priv[idx] = priv; m_wp[idx] = wp;
  endtask

  task automatic sweep(string tag);
    for (int t = 0; t < 256; t++) begin
      for (int m = 0; m < 4; m++) begin
        bit eh, ef;
        @(negedge clk);
        acc_addr  = {t[7:0], 24'(t * 24'h010101) ^ 24'h5AC31E};
        acc_super = m[0];
        acc_write = m[1];
        #1;
        eh = win_match(0, t[7:0], m[0]) || win_match(1, t[7:0], m[0]);
        ef = m[1] && ((win_match(0, t[7:0], m[0]) && m_wp[0]) ||
                      (win_match(1, t[7:0], m[0]) && m_wp[1]));
        check({tag, " hit"}, {31'b0, hit}, {31'b0, eh});
        check({tag, " fault R7"}, {31'b0, wr_fault}, {31'b0, ef});
        check({tag, " phys R6"}, phys_addr, eh ? acc_addr : 32'h0);
      end
    end
  endtask

  initial begin
    for (int w = 0; w < 2; w++) begin
      m_en[w] = 0; m_base[w] = 0; m_mask[w] = 0; m_priv[w] = 0; m_wp[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, nothing matches
    sweep("R1");
    // R2: 16-entry window at 0x40..0x4F, both modes
    put_win(0, 1, 8'h40, 8'h0F, 2'b10, 0);
    sweep("R2");
    // R4 and R3 with R5 user-only filter and R7 protection; R9: win0 rewrite only
    put_win(0, 0, 8'h40, 8'h0F, 2'b11, 1);
    put_win(1, 1, 8'h00, 8'hFF, 2'b00, 1);
    sweep("R3 R4 R5");
    // R8 overlap, R5 supervisor-only, R7 protection from either window
    put_win(0, 1, 8'hA5, 8'h00, 2'b01, 1);
    put_win(1, 1, 8'hA0, 8'h0F, 2'b11, 0);
    sweep("R8 R5");
    // R9: rewrite window 1 only; window 0 must keep its setting
    put_win(1, 1, 8'h3C, 8'h03, 2'b10, 1);
    sweep("R9");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule